// File: doc/BRIEF.md
# Staggered Parallel Output Driver

This block drives a 24-bit parallel pixel bus and its companion clock toward a display timing controller. It runs from an internal clock eight times faster than the pixel rate, so each pixel period is eight sub-phases long. The data bits are grouped into three byte-wide banks. Each bank loads the captured pixel at a different sub-phase, so the whole bus never switches in one instant. The output clock's active edge comes later in the period, after every bank has settled. It stays well ahead of the next pixel's first bank update, which leaves margin on both sides of the sampling edge.

Two timing modes are available. They are selected per pixel. Fixed mode keeps bank offsets and the clock edge at constant positions. Spread mode uses a pseudo-random sequence to pick, for each pixel, a new order of the three bank slots. It also moves the clock edge one sub-phase earlier or later. This spreads the switching energy over frequency. A static input chooses whether the rising or the falling edge of the output clock is the active one.

The upstream source presents a new pixel whenever the block raises its pixel request. The pixel word and the mode select are both sampled at the end of that cycle.

Top module: `stagger_out_drv`

## Requirements
- R1: An active-low reset asserts asynchronously and is released synchronously. While reset is low, `out_data` is all zero, `out_clk` equals `edge_sel` (the inactive level), and `pix_req` is low.
- R2: Each pixel period is 8 internal cycles. `pix_req` is high only in the last cycle of the period. `pix_data` and `spread_en` are sampled at the clock edge that ends that cycle, and changes to them in any other cycle have no effect on the outputs.
- R3: Bank 0 is `out_data[7:0]`, bank 1 is `[15:8]` and bank 2 is `[23:16]`. Sub-phase 0 is the cycle right after the `pix_req` cycle. Each bank changes at most once per pixel, only within sub-phases 1 to 3, and holds the captured pixel from sub-phase 3 on.
- R4: In fixed mode (`spread_en` = 0 when sampled), bank k shows its new value at sub-phase k+1, and the active clock edge appears at sub-phase 5.
- R5: In spread mode (`spread_en` = 1 when sampled), the three banks show their new values at three distinct sub-phases within 1 to 3, and the active clock edge appears at sub-phase 4, 5 or 6.
- R6: Over successive spread-mode pixels, the bank order and the clock edge position both vary. At least three different bank orders and at least two edge positions occur within 60 pixels.
- R7: In any internal cycle, at most `MAX_PER_PH` banks (default 1) change value.
- R8: No bank changes in the cycle where the active clock edge appears, nor in the cycle that follows it. Every bank change of a pixel comes before that pixel's active edge.
- R9: With `edge_sel` = 0 the active edge is rising, and with `edge_sel` = 1 it is falling. There is exactly one active edge per pixel period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, 8 times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en | input | 1 | Mode select for the next pixel: 1 spread, 0 fixed |
| edge_sel | input | 1 | Active output clock edge: 0 rising, 1 falling; static outside reset |
| pix_data | input | 24 | Pixel word, sampled at the end of the `pix_req` cycle |
| pix_req | output | 1 | High in the last sub-phase of each pixel period |
| out_data | output | 24 | Staggered parallel data output, three 8-bit banks |
| out_clk | output | 1 | Output pixel clock |

## Verification
On every cycle, the bound checker enforces the per-cycle switching limit and confines bank changes to the update window. It also keeps the active clock edge within its allowed sub-phases, pinned to sub-phase 5 in fixed mode, and confirms that the data bus is quiet on the edge cycle and the cycle after it. Other properties need a whole pixel or many pixels to show. These are covered only by the bench's scenarios: each bank lands on the correct captured value exactly once, fixed mode gives the exact bank-to-slot mapping, spread mode actually varies its orders and edge positions, mid-pixel input changes are ignored, and the falling-edge setting behaves correctly.

// File: rtl/sod_pkg.sv
package sod_pkg;

  typedef enum logic {
    MODE_FIXED  = 1'b0,
    MODE_SPREAD = 1'b1
  } sod_mode_e;

  localparam int LFSR_W = 8;

  // Maximal-length sequence, polynomial x^8 + x^6 + x^5 + x^4 + 1
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  // Slot of a bank group after optional reflection and rotation
  function automatic int unsigned slot_of(input int unsigned grp,
                                          input int unsigned nslot,
                                          input logic refl,
                                          input int unsigned rot);
    int unsigned g;
    g = refl ? (nslot - 1 - grp) : grp;
    return (g + rot) % nslot;
  endfunction

endpackage

// File: rtl/sod_rst_sync.sv
module sod_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sod_phase_ctr.sv
module sod_phase_ctr #(
  parameter  int PHASES = 8,
  localparam int PH_W   = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph_o,
  output logic [PH_W-1:0] ph_nxt_o,
  output logic            last_o
);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;
  logic            last;

  always_comb begin
    last = (ph_q == PH_W'(PHASES - 1));
    ph_d = last ? '0 : PH_W'(ph_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign ph_o     = ph_q;
  assign ph_nxt_o = ph_d;
  assign last_o   = last;

endmodule

// File: rtl/sod_sched.sv
module sod_sched
  import sod_pkg::*;
#(
  parameter  int NUM_BANKS  = 3,
  parameter  int MAX_PER_PH = 1,
  parameter  int PHASES     = 8,
  parameter  int CLK_PH     = 5,
  parameter  logic [LFSR_W-1:0] SEED = 8'hA5,
  localparam int PH_W       = $clog2(PHASES),
  localparam int NSLOT      = (NUM_BANKS + MAX_PER_PH - 1) / MAX_PER_PH
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           adv_i,
  input  logic                           spread_i,
  output logic [NUM_BANKS-1:0][PH_W-1:0] slot_o,
  output logic [PH_W-1:0]                clk_ph_o,
  output sod_mode_e                      mode_o
);

  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [PH_W-1:0]   slot_q [NUM_BANKS];
  logic [PH_W-1:0]   slot_d [NUM_BANKS];
  logic [PH_W-1:0]   clk_ph_q, clk_ph_d;
  sod_mode_e         mode_q, mode_d;
  int unsigned       rot;
  logic              refl;

  // Shared next-state: sequence, mode, clock edge position
  always_comb begin
    rot      = int'(lfsr_q[3:0]) % NSLOT;
    refl     = lfsr_q[4];
    lfsr_d   = lfsr_q;
    mode_d   = mode_q;
    clk_ph_d = clk_ph_q;
    if (adv_i) begin
      lfsr_d = lfsr_step(lfsr_q);
      mode_d = spread_i ? MODE_SPREAD : MODE_FIXED;
      if (spread_i) begin
        case (lfsr_q[6:5])
          2'b00:   clk_ph_d = PH_W'(CLK_PH - 1);
          2'b11:   clk_ph_d = PH_W'(CLK_PH + 1);
          default: clk_ph_d = PH_W'(CLK_PH);
        endcase
      end else begin
        clk_ph_d = PH_W'(CLK_PH);
      end
    end
  end

  // Per-bank slot selection
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
    localparam int GRP = b / MAX_PER_PH;
    always_comb begin
      slot_d[b] = slot_q[b];
      if (adv_i) begin
        if (spread_i) slot_d[b] = PH_W'(slot_of(GRP, NSLOT, refl, rot));
        else          slot_d[b] = PH_W'(GRP);
      end
    end
    assign slot_o[b] = slot_q[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q   <= SEED;
      mode_q   <= MODE_FIXED;
      clk_ph_q <= PH_W'(CLK_PH);
      for (int b = 0; b < NUM_BANKS; b++) slot_q[b] <= PH_W'(b / MAX_PER_PH);
    end else begin
      lfsr_q   <= lfsr_d;
      mode_q   <= mode_d;
      clk_ph_q <= clk_ph_d;
      for (int b = 0; b < NUM_BANKS; b++) slot_q[b] <= slot_d[b];
    end
  end

  assign clk_ph_o = clk_ph_q;
  assign mode_o   = mode_q;

endmodule

// File: rtl/sod_bank.sv
module sod_bank #(
  parameter int BW   = 8,
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_i,
  input  logic [PH_W-1:0] slot_i,
  input  logic [PH_W-1:0] ph_i,
  input  logic [BW-1:0]   d_i,
  output logic [BW-1:0]   q_o
);

  logic [BW-1:0] hold_q, hold_d;
  logic [BW-1:0] out_q, out_d;
  logic          upd_en;

  always_comb begin
    upd_en = !cap_i && (ph_i == slot_i);
    hold_d = cap_i  ? d_i    : hold_q;
    out_d  = upd_en ? hold_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      hold_q <= hold_d;
      out_q  <= out_d;
    end
  end

  assign q_o = out_q;

endmodule

// File: rtl/sod_clk_gen.sv
module sod_clk_gen #(
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] ph_nxt_i,
  input  logic [PH_W-1:0] clk_ph_i,
  input  logic            edge_sel_i,
  output logic            out_clk_o
);

  logic lvl_q, lvl_d;

  // High from the active sub-phase to the end of the period and through sub-phase 0
  always_comb begin
    lvl_d = (ph_nxt_i == '0) || (ph_nxt_i >= clk_ph_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign out_clk_o = lvl_q ^ edge_sel_i;

endmodule

// File: rtl/stagger_out_drv.sv
module stagger_out_drv
  import sod_pkg::*;
#(
  parameter  int DATA_W     = 24,
  parameter  int NUM_BANKS  = 3,
  parameter  int MAX_PER_PH = 1,
  parameter  int PHASES     = 8,
  parameter  int CLK_PH     = 5,
  localparam int PH_W       = $clog2(PHASES),
  localparam int BW         = DATA_W / NUM_BANKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spread_en,
  input  logic              edge_sel,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_req,
  output logic [DATA_W-1:0] out_data,
  output logic              out_clk
);

  logic                           rst_s_n;
  logic [PH_W-1:0]                ph_q;
  logic [PH_W-1:0]                ph_nxt;
  logic                           last_ph;
  logic [NUM_BANKS-1:0][PH_W-1:0] slot;
  logic [PH_W-1:0]                clk_ph;
  sod_mode_e                      mode_q;

  sod_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  sod_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .ph_o     (ph_q),
    .ph_nxt_o (ph_nxt),
    .last_o   (last_ph)
  );

  sod_sched #(
    .NUM_BANKS  (NUM_BANKS),
    .MAX_PER_PH (MAX_PER_PH),
    .PHASES     (PHASES),
    .CLK_PH     (CLK_PH)
  ) u_sched (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .adv_i    (last_ph),
    .spread_i (spread_en),
    .slot_o   (slot),
    .clk_ph_o (clk_ph),
    .mode_o   (mode_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sod_bank #(.BW(BW), .PH_W(PH_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .cap_i  (last_ph),
      .slot_i (slot[b]),
      .ph_i   (ph_q),
      .d_i    (pix_data[b*BW +: BW]),
      .q_o    (out_data[b*BW +: BW])
    );
  end

  sod_clk_gen #(.PH_W(PH_W)) u_clk (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .ph_nxt_i   (ph_nxt),
    .clk_ph_i   (clk_ph),
    .edge_sel_i (edge_sel),
    .out_clk_o  (out_clk)
  );

  assign pix_req = last_ph;

endmodule

// File: rtl/sod_chk.sv
module sod_chk
  import sod_pkg::*;
#(
  parameter  int DATA_W     = 24,
  parameter  int NUM_BANKS  = 3,
  parameter  int MAX_PER_PH = 1,
  parameter  int PHASES     = 8,
  parameter  int CLK_PH     = 5,
  localparam int PH_W       = $clog2(PHASES),
  localparam int BW         = DATA_W / NUM_BANKS,
  localparam int NSLOT      = (NUM_BANKS + MAX_PER_PH - 1) / MAX_PER_PH
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PH_W-1:0]   ph,
  input sod_mode_e         mode,
  input logic              edge_sel,
  input logic [DATA_W-1:0] out_data,
  input logic              out_clk
);

  logic [DATA_W-1:0]    prev_data_q;
  logic                 prev_raw_q;
  logic [NUM_BANKS-1:0] chg;
  logic                 raw;
  logic                 act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_data_q <= '0;
      prev_raw_q  <= 1'b0;
    end else begin
      prev_data_q <= out_data;
      prev_raw_q  <= raw;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chg
    assign chg[b] = (prev_data_q[b*BW +: BW] != out_data[b*BW +: BW]);
  end

  assign raw = out_clk ^ edge_sel;
  assign act = raw & ~prev_raw_q;

  // R7
  max_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chg) <= MAX_PER_PH);

  // R3
  bank_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |-> (ph >= PH_W'(1) && ph <= PH_W'(NSLOT)));

  // R4
  fixed_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && mode == MODE_FIXED) |-> (ph == PH_W'(CLK_PH)));

  // R5
  spread_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (ph >= PH_W'(CLK_PH - 1) && ph <= PH_W'(CLK_PH + 1)));

  // R8
  setup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (chg == '0));

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> (chg == '0));

endmodule

bind stagger_out_drv sod_chk #(
  .DATA_W     (DATA_W),
  .NUM_BANKS  (NUM_BANKS),
  .MAX_PER_PH (MAX_PER_PH),
  .PHASES     (PHASES),
  .CLK_PH     (CLK_PH)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .ph       (ph_q),
  .mode     (mode_q),
  .edge_sel (edge_sel),
  .out_data (out_data),
  .out_clk  (out_clk)
);

// File: tb/stagger_out_drv_tb.sv
`timescale 1ns/1ps
module stagger_out_drv_tb_top;

  logic        clk;
  logic        rst_n;
  logic        spread_en;
  logic        edge_sel;
  logic [23:0] pix_data;
  logic        pix_req;
  logic [23:0] out_data;
  logic        out_clk;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [23:0] exp_q;
  bit          seen_perm [64];
  bit          seen_edge [8];

  stagger_out_drv dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .spread_en (spread_en),
    .edge_sel  (edge_sel),
    .pix_data  (pix_data),
    .pix_req   (pix_req),
    .out_data  (out_data),
    .out_clk   (out_clk)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_req();
    do @(negedge clk); while (!pix_req);
  endtask

  // Mask with every byte nonzero so every bank changes
  function automatic logic [23:0] rand_mask();
    return {8'($urandom_range(1, 255)), 8'($urandom_range(1, 255)), 8'($urandom_range(1, 255))};
  endfunction

  function automatic bit in_range(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // Precondition: positioned at a negedge of a pix_req cycle
  task automatic run_pixel(input logic [23:0] mask, input bit spread, input bit mid_scramble, input bit mid_flip);
    logic [23:0] d;
    logic [23:0] prev;
    logic        raw_prev;
    int          chg_k [3];
    int          cnt [3];
    int          edge_k;
    int          edges;
    int          per_k;
    d = exp_q ^ mask;
    pix_data  = d;
    spread_en = spread;
    prev      = out_data;
    raw_prev  = out_clk ^ edge_sel;
    for (int b = 0; b < 3; b++) begin chg_k[b] = -1; cnt[b] = 0; end
    edge_k = -1; edges = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      per_k = 0;
      for (int b = 0; b < 3; b++) begin
        if (out_data[b*8 +: 8] != prev[b*8 +: 8]) begin
          chg_k[b] = k; cnt[b]++; per_k++;
        end
      end
      // R7: at most one bank per sub-phase
      chk(per_k <= 1, "R7", per_k, 1);
      if ((out_clk ^ edge_sel) && !raw_prev) begin edges++; edge_k = k; end
      // R2: request only in the last sub-phase
      chk(pix_req == (k == 7), "R2", pix_req, (k == 7));
      prev     = out_data;
      raw_prev = out_clk ^ edge_sel;
      if (k == 1 && mid_scramble) pix_data = 24'($urandom());
      if (k == 2 && mid_flip) spread_en = ~spread_en;
    end
    // R3 and R2: captured word lands, later input changes ignored
    chk(out_data == d, "R3", out_data, d);
    for (int b = 0; b < 3; b++) begin
      chk(cnt[b] == 1, "R3", cnt[b], 1);
      chk(in_range(chg_k[b], 1, 3), "R3", chg_k[b], 2);
    end
    // R9: one active edge per pixel
    chk(edges == 1, "R9", edges, 1);
    // R8: edge after all bank changes
    chk(edge_k > chg_k[0] && edge_k > chg_k[1] && edge_k > chg_k[2], "R8", edge_k, 4);
    if (!spread) begin
      // R4: fixed slots and edge
      for (int b = 0; b < 3; b++) chk(chg_k[b] == b + 1, "R4", chg_k[b], b + 1);
      chk(edge_k == 5, "R4", edge_k, 5);
    end else begin
      // R5: distinct slots, edge window
      chk(chg_k[0] != chg_k[1] && chg_k[1] != chg_k[2] && chg_k[0] != chg_k[2],
          "R5", {chg_k[0][7:0], chg_k[1][7:0], chg_k[2][7:0]}, 24'h010203);
      chk(in_range(edge_k, 4, 6), "R5", edge_k, 5);
      if (in_range(chg_k[0], 0, 3) && in_range(chg_k[1], 0, 3) && in_range(chg_k[2], 0, 3))
        seen_perm[chg_k[0]*16 + chg_k[1]*4 + chg_k[2]] = 1'b1;
      if (in_range(edge_k, 0, 7)) seen_edge[edge_k] = 1'b1;
    end
    exp_q = d;
  endtask

  task automatic reset_check(input logic esel);
    edge_sel = esel;
    repeat (3) @(negedge clk);
    // R1
    chk(out_data == 24'h0, "R1", out_data, 0);
    chk(out_clk == esel, "R1", out_clk, esel);
    chk(pix_req == 1'b0, "R1", pix_req, 0);
    rst_n = 1'b1;
    exp_q = '0;
    wait_req();
  endtask

  initial begin
    int np, ne;
    void'($urandom(32'd4242));
    rst_n = 1'b0; spread_en = 1'b0; edge_sel = 1'b0; pix_data = '0;
    reset_check(1'b0);

    // Directed fixed-mode corners
    run_pixel(24'hFFFFFF, 1'b0, 1'b0, 1'b0);
    run_pixel(24'h010101, 1'b0, 1'b0, 1'b0);
    run_pixel(24'h800180, 1'b0, 1'b1, 1'b0);
    run_pixel(24'hFFFFFF, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) run_pixel(rand_mask(), 1'b0, i[0], 1'b0);

    // R2: mode change mid-pixel ignored until next capture
    run_pixel(rand_mask(), 1'b0, 1'b0, 1'b1);
    run_pixel(rand_mask(), 1'b1, 1'b1, 1'b1);
    run_pixel(rand_mask(), 1'b0, 1'b0, 1'b1);

    // Spread mode, random data
    for (int i = 0; i < 60; i++) run_pixel(rand_mask(), 1'b1, i[1], 1'b0);
    np = 0; ne = 0;
    for (int i = 0; i < 64; i++) np += seen_perm[i];
    for (int i = 0; i < 8; i++) ne += seen_edge[i];
    // R6: variety of orders and edge positions
    chk(np >= 3, "R6", np, 3);
    chk(ne >= 2, "R6", ne, 2);

    // Asynchronous reset mid-pixel, then falling-edge operation
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    // R1: immediate effect
    chk(out_data == 24'h0, "R1", out_data, 0);
    reset_check(1'b1);
    for (int i = 0; i < 8; i++)  run_pixel(rand_mask(), 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) run_pixel(rand_mask(), 1'b1, 1'b0, 1'b0);
    run_pixel(24'hFFFFFF, 1'b1, 1'b0, 1'b0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule